// File: doc/BRIEF.md
# Motion Adaptive Deinterlacing Interpolator

This block produces the pixel of a missing scan line when an interlaced field is turned into a progressive frame. It handles one pixel per clock. For every pixel it compares the co-sited samples of the previous and next fields. If the two agree within a programmable threshold, the pixel is treated as static and is filled from those neighbouring fields. If they do not agree, it is treated as moving and is filled only from the current field. In that case an edge-directed filter picks the direction with the best match out of two diagonals and the vertical.

The surrounding video pipeline supplies the neighbour data: a three-pixel window from the field line above the missing line, a three-pixel window from the line below, and the previous-field and next-field samples. A bypass flag is used for progressive sources and passes the current-line pixel through unchanged. Each output comes with a valid strobe and a motion flag, both aligned to the pixel.

Top module: `deint_interp`

## Requirements
- R1: An output appears exactly two clock edges after the input that produced it. `out_valid` is `in_valid` delayed by two clocks, and `out_moving` is never high while `out_valid` is low.
- R2: The motion metric is |`prev_px` − `next_px`|. A pixel is moving only when the metric is strictly greater than `motion_thr`. A metric equal to the threshold counts as static. `out_moving` reports this decision.
- R3: A static pixel is output as (`prev_px` + `next_px` + 1) >> 1, computed without overflow, so 1023 and 1023 give 1023.
- R4: A moving pixel uses three pairs. The pairs are left-down (up[0], dn[2]), vertical (up[1], dn[1]) and right-down (up[2], dn[0]). The window fields are up[k] = `up_win[10k+9:10k]`, and likewise for dn. The pair with the smallest absolute difference is averaged with rounding: (a + b + 1) >> 1.
- R5: When the vertical pair ties with the best diagonal pair, the vertical pair is chosen.
- R6: When both diagonal pairs tie below the vertical difference, the left-down pair (up[0], dn[2]) is chosen.
- R7: With `bypass` high, `out_px` equals the centre pixel of the upper window (up[1]) and `out_moving` is low, whatever the other inputs are.
- R8: While `rst` is high at a clock edge, all outputs are cleared to zero on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel strobe |
| up_win | input | 30 | Upper field line window: left, centre, right in ascending 10-bit fields |
| dn_win | input | 30 | Lower field line window, same packing |
| prev_px | input | 10 | Co-sited previous-field sample |
| next_px | input | 10 | Co-sited next-field sample |
| motion_thr | input | 10 | Motion threshold |
| bypass | input | 1 | Progressive pass-through select |
| out_valid | output | 1 | Output pixel strobe |
| out_px | output | 10 | Interpolated pixel |
| out_moving | output | 1 | Pixel was judged moving |

## Verification
The assertions check some properties on every cycle. These are the two-cycle alignment of the valid strobe, the rule that the motion flag only appears alongside valid, the bypass pass-through of the upper centre pixel, and the fact that a static average lies between its two field samples. They also check that a zero vertical difference always selects the vertical pair. Other behaviour only shows up in the bench scenarios. This covers the exact threshold boundary where equality counts as static, and which diagonal wins when differences tie or one diagonal is strictly best. It also covers rounding at the extremes of the 10-bit range and clearing on reset.

// File: rtl/deint_pkg.sv
package deint_pkg;
  typedef enum logic [1:0] {DIR_LEFT = 2'd0, DIR_VERT = 2'd1, DIR_RIGHT = 2'd2} dir_e;

  function automatic logic [9:0] abs_diff10(input logic [9:0] a, input logic [9:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic logic [9:0] avg_round10(input logic [9:0] a, input logic [9:0] b);
    logic [10:0] s;
    s = {1'b0, a} + {1'b0, b} + 11'd1;
    return s[10:1];
  endfunction
endpackage

// File: rtl/deint_motion_detect.sv
module deint_motion_detect #(
  parameter int PIX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] prev_px,
  input  logic [PIX_W-1:0] next_px,
  input  logic [PIX_W-1:0] thr,
  output logic             s1_moving,
  output logic [PIX_W-1:0] s1_static
);
  localparam int SUM_W = PIX_W + 1;

  logic [PIX_W-1:0] metric;
  logic [SUM_W-1:0] sum_r;
  logic             warm;

  always_comb begin
    metric = (prev_px > next_px) ? (prev_px - next_px) : (next_px - prev_px);
    sum_r  = {1'b0, prev_px} + {1'b0, next_px} + SUM_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_moving <= 1'b0;
      s1_static <= '0;
      warm      <= 1'b0;
    end else begin
      s1_moving <= (metric > thr);
      s1_static <= sum_r[SUM_W-1:1];
      warm      <= 1'b1;
    end
  end

  AST_STATIC_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    warm |-> ((s1_static >= (($past(prev_px) < $past(next_px)) ? $past(prev_px) : $past(next_px))) &&
              (s1_static <= (($past(prev_px) > $past(next_px)) ? $past(prev_px) : $past(next_px))))); // R3
endmodule

// File: rtl/deint_edge_dir.sv
module deint_edge_dir #(
  parameter int PIX_W = 10,
  parameter int TAPS  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [TAPS*PIX_W-1:0] up_win,
  input  logic [TAPS*PIX_W-1:0] dn_win,
  output logic [PIX_W-1:0]      s1_diag
);
  import deint_pkg::*;
  localparam int SUM_W = PIX_W + 1;

  logic [PIX_W-1:0] up_px [TAPS];
  logic [PIX_W-1:0] dn_px [TAPS];

  genvar gi;
  generate
    for (gi = 0; gi < TAPS; gi++) begin : g_unpack
      assign up_px[gi] = up_win[gi*PIX_W +: PIX_W];
      assign dn_px[gi] = dn_win[gi*PIX_W +: PIX_W];
    end
  endgenerate

  logic [PIX_W-1:0] d_left, d_vert, d_right;
  logic [PIX_W-1:0] pa, pb;
  logic [SUM_W-1:0] sum_r;
  dir_e             pick;
  logic             warm;

  always_comb begin
    d_left  = (up_px[0] > dn_px[2]) ? (up_px[0] - dn_px[2]) : (dn_px[2] - up_px[0]);
    d_vert  = (up_px[1] > dn_px[1]) ? (up_px[1] - dn_px[1]) : (dn_px[1] - up_px[1]);
    d_right = (up_px[2] > dn_px[0]) ? (up_px[2] - dn_px[0]) : (dn_px[0] - up_px[2]);
    if (d_vert <= d_left && d_vert <= d_right) pick = DIR_VERT;
    else if (d_left <= d_right)                pick = DIR_LEFT;
    else                                       pick = DIR_RIGHT;
    case (pick)
      DIR_LEFT:  begin pa = up_px[0]; pb = dn_px[2]; end
      DIR_RIGHT: begin pa = up_px[2]; pb = dn_px[0]; end
      default:   begin pa = up_px[1]; pb = dn_px[1]; end
    endcase
    sum_r = {1'b0, pa} + {1'b0, pb} + SUM_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_diag <= '0;
      warm    <= 1'b0;
    end else begin
      s1_diag <= sum_r[SUM_W-1:1];
      warm    <= 1'b1;
    end
  end

  AST_VERT_ZERO_DIFF: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(up_win[PIX_W +: PIX_W]) == $past(dn_win[PIX_W +: PIX_W]))
      |-> (s1_diag == $past(up_win[PIX_W +: PIX_W]))); // R5
endmodule

// File: rtl/deint_out_stage.sv
module deint_out_stage #(
  parameter int PIX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s1_valid,
  input  logic             s1_bypass,
  input  logic             s1_moving,
  input  logic [PIX_W-1:0] s1_static,
  input  logic [PIX_W-1:0] s1_diag,
  input  logic [PIX_W-1:0] s1_thru,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_px,
  output logic             out_moving
);
  logic [PIX_W-1:0] pick_px;

  always_comb begin
    if (s1_bypass)      pick_px = s1_thru;
    else if (s1_moving) pick_px = s1_diag;
    else                pick_px = s1_static;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_px     <= '0;
      out_moving <= 1'b0;
    end else begin
      out_valid  <= s1_valid;
      out_px     <= pick_px;
      out_moving <= s1_valid && s1_moving && !s1_bypass;
    end
  end

  AST_FLAG_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    out_moving |-> out_valid); // R1
endmodule

// File: rtl/deint_interp.sv
module deint_interp #(
  parameter int PIX_W = 10,
  parameter int TAPS  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [TAPS*PIX_W-1:0] up_win,
  input  logic [TAPS*PIX_W-1:0] dn_win,
  input  logic [PIX_W-1:0]      prev_px,
  input  logic [PIX_W-1:0]      next_px,
  input  logic [PIX_W-1:0]      motion_thr,
  input  logic                  bypass,
  output logic                  out_valid,
  output logic [PIX_W-1:0]      out_px,
  output logic                  out_moving
);
  localparam int CTR = TAPS / 2;

  logic             s1_valid, s1_bypass, s1_moving;
  logic [PIX_W-1:0] s1_static, s1_diag, s1_thru;
  logic [1:0]       warm;

  deint_motion_detect #(.PIX_W(PIX_W)) u_motion (
    .clk(clk), .rst(rst), .prev_px(prev_px), .next_px(next_px), .thr(motion_thr),
    .s1_moving(s1_moving), .s1_static(s1_static)
  );

  deint_edge_dir #(.PIX_W(PIX_W), .TAPS(TAPS)) u_edge (
    .clk(clk), .rst(rst), .up_win(up_win), .dn_win(dn_win), .s1_diag(s1_diag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_bypass <= 1'b0;
      s1_thru   <= '0;
      warm      <= 2'd0;
    end else begin
      s1_valid  <= in_valid;
      s1_bypass <= bypass;
      s1_thru   <= up_win[CTR*PIX_W +: PIX_W];
      if (warm != 2'd2) warm <= warm + 2'd1;
    end
  end

  deint_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_bypass(s1_bypass),
    .s1_moving(s1_moving), .s1_static(s1_static), .s1_diag(s1_diag), .s1_thru(s1_thru),
    .out_valid(out_valid), .out_px(out_px), .out_moving(out_moving)
  );

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R1

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
    ((warm == 2'd2) && $past(bypass, 2))
      |-> (out_px == $past(up_win[CTR*PIX_W +: PIX_W], 2) && !out_moving)); // R7
endmodule

// File: tb/tb_deint_interp.sv
module tb_deint_interp;
  typedef struct packed {
    logic [9:0] u0, u1, u2, d0, d1, d2, pv, nx, th;
    logic       byp;
    logic [9:0] ex;
    logic       mv;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{10'd1, 10'd2, 10'd3, 10'd4, 10'd5, 10'd6, 10'd100, 10'd103, 10'd5, 1'b0, 10'd102, 1'b0, 4'd3},   // R3
    '{10'd9, 10'd9, 10'd9, 10'd9, 10'd9, 10'd9, 10'd200, 10'd210, 10'd10, 1'b0, 10'd205, 1'b0, 4'd2},  // R2 equal
    '{10'd50, 10'd60, 10'd70, 10'd90, 10'd64, 10'd30, 10'd200, 10'd211, 10'd10, 1'b0, 10'd62, 1'b1, 4'd2}, // R2 above
    '{10'd400, 10'd10, 10'd900, 10'd0, 10'd500, 10'd401, 10'd0, 10'd1023, 10'd0, 1'b0, 10'd401, 1'b1, 4'd4}, // R4 left
    '{10'd5, 10'd300, 10'd600, 10'd599, 10'd0, 10'd700, 10'd0, 10'd1023, 10'd0, 1'b0, 10'd600, 1'b1, 4'd4}, // R4 right
    '{10'd100, 10'd200, 10'd0, 10'd900, 10'd210, 10'd110, 10'd0, 10'd1023, 10'd0, 1'b0, 10'd205, 1'b1, 4'd5}, // R5
    '{10'd100, 10'd0, 10'd300, 10'd304, 10'd1000, 10'd104, 10'd0, 10'd1023, 10'd0, 1'b0, 10'd102, 1'b1, 4'd6}, // R6
    '{10'd1, 10'd777, 10'd3, 10'd4, 10'd5, 10'd6, 10'd0, 10'd1023, 10'd0, 1'b1, 10'd777, 1'b0, 4'd7},   // R7
    '{10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd1023, 10'd1023, 10'd0, 1'b0, 10'd1023, 1'b0, 4'd3}, // R3 top
    '{10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd1023, 10'd1023, 1'b0, 10'd512, 1'b0, 4'd2},  // R2 max thr
    '{10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd1, 10'd0, 1'b1, 10'd0, 1'b0, 4'd7},          // R7 flag low
    '{10'd8, 10'd8, 10'd8, 10'd8, 10'd8, 10'd8, 10'd0, 10'd1, 10'd3, 1'b0, 10'd1, 1'b0, 4'd3}           // R3 round
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [29:0] up_win = '0, dn_win = '0;
  logic [9:0]  prev_px = '0, next_px = '0, motion_thr = '0;
  logic        bypass = 1'b0;
  logic        out_valid, out_moving;
  logic [9:0]  out_px;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  deint_interp dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .up_win(up_win), .dn_win(dn_win),
    .prev_px(prev_px), .next_px(next_px), .motion_thr(motion_thr), .bypass(bypass),
    .out_valid(out_valid), .out_px(out_px), .out_moving(out_moving)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    up_win = {v.u2, v.u1, v.u0};
    dn_win = {v.d2, v.d1, v.d0};
    prev_px = v.pv; next_px = v.nx; motion_thr = v.th; bypass = v.byp;
    in_valid = 1'b1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 valid", int'(out_valid), 0);
    check("R8 px", int'(out_px), 0);
    check("R8 moving", int'(out_moving), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d row %0d px", VECS[i].req, i), int'(out_px), int'(VECS[i].ex));
      check($sformatf("R%0d row %0d moving", VECS[i].req, i), int'(out_moving), int'(VECS[i].mv));
      check($sformatf("R1 row %0d valid", i), int'(out_valid), 1);
    end

    // R1: single-cycle pulse appears exactly two edges later, then clears
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 idle", int'(out_valid), 0);
    apply(VECS[2]);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 one edge", int'(out_valid), 0);
    @(negedge clk);
    check("R1 two edges", int'(out_valid), 1);
    check("R1 flag aligned", int'(out_moving), 1);
    @(negedge clk);
    check("R1 three edges", int'(out_valid), 0);
    check("R1 flag dropped", int'(out_moving), 0);

    // R1: back-to-back stream keeps order
    apply(VECS[3]);
    @(negedge clk);
    apply(VECS[4]);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 stream first", int'(out_px), 401);
    @(negedge clk);
    check("R1 stream second", int'(out_px), 600);

    // R8: reset clears outputs mid-stream
    apply(VECS[7]);
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8 mid valid", int'(out_valid), 0);
    check("R8 mid px", int'(out_px), 0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule